// File: doc/BRIEF.md
# Next Fetch Address Predictor

This block sits at the head of a decoupled instruction fetch engine. Every cycle it takes the current fetch address and, in the same cycle, returns where fetch should go next. It also returns how many instructions to fetch there, the physical address of that target and the instruction-cache way that holds it. With these the fetch engine can skip address translation and way selection whenever the predictor hits. The table is direct-mapped, has a partial tag, and is trained by an update port that decode or the slower predictors drive.

Slower, more accurate predictors can override a prediction several cycles late. A redirect sends their corrected target straight through to the output. It also retrains the entry for the branch and puts the private return stack back into a known state. A small return stack, separate from the architectural one, predicts the return targets of closely spaced call/return pairs. Indirect branches that are trained as low-confidence do not guess. They hold fetch in a stall until an externally resolved target arrives.

Top module: `nfp_predictor`

## Requirements
- R1: A lookup whose index entry is invalid or whose tag differs predicts the sequential address `look_addr + 4*MAX_W` with width MAX_W (16), and deasserts `pred_pa_vld`.
- R2: A lookup that hits a plain entry returns, in the same cycle, the trained target, width, physical address and way, with `pred_pa_vld` high.
- R3: The index is address bits [7:2] and the tag is bits [15:8]. Two addresses with the same index and different tags do not alias.
- R4: When an update and a lookup to the same index happen in the same cycle, the update is written, and the lookup returns the newly written data.
- R5: A hit on a low-confidence entry gives `pred_vld`=0 and `pred_stall`=1. The stall persists, and lookups are ignored, until a resolved target or a redirect arrives.
- R6: While the block is stalled, a resolved target is passed out with `pred_vld`=1, width MAX_W and `pred_pa_vld`=0, and the stall ends in that cycle.
- R7: Branch kind codes are 0 plain, 1 call, 2 return, 3 indirect. A call hit pushes `look_addr + 4*(slot+1)`. A return hit on a non-empty stack pops and predicts the popped address with width MAX_W and `pred_pa_vld`=0.
- R8: A return hit on an empty stack predicts as a plain entry, using the trained target.
- R9: The stack holds RAS_D (8) addresses. Pushing past that depth overwrites the oldest entry, and the count saturates.
- R10: A redirect drives its target, width, physical address and way onto the output in that cycle, with `pred_vld` and `pred_pa_vld` high. It also retrains the entry indexed by `redir_pc`.
- R11: A redirect with `redir_ckpt_vld` restores the return stack to a checkpoint earlier taken from `ras_ckpt`. A redirect without a checkpoint empties the stack.
- R12: When a redirect and an update target the same entry in the same cycle, the redirect data is stored.
- R13: After reset every entry is invalid, and no prediction and no stall is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| look_vld | input | 1 | Lookup request this cycle |
| look_addr | input | ADDR_W | Current fetch address |
| upd_vld | input | 1 | Train one entry |
| upd_pc | input | ADDR_W | Fetch address of the trained block |
| upd_target | input | ADDR_W | Next fetch address |
| upd_paddr | input | PADDR_W | Physical address of the target |
| upd_way | input | WAY_W | Cache way of the target line |
| upd_width | input | WID_W | Instructions to fetch at the target |
| upd_kind | input | 2 | Branch kind code |
| upd_slot | input | SLOT_W | Slot of the branch in its block |
| upd_low | input | 1 | Low-confidence flag |
| redir_vld | input | 1 | Late override |
| redir_pc | input | ADDR_W | Fetch address whose entry is retrained |
| redir_target | input | ADDR_W | Corrected next fetch address |
| redir_paddr | input | PADDR_W | Physical address of the corrected target |
| redir_way | input | WAY_W | Way of the corrected target |
| redir_width | input | WID_W | Width at the corrected target |
| redir_kind | input | 2 | Branch kind for retraining |
| redir_slot | input | SLOT_W | Branch slot for retraining |
| redir_ckpt_vld | input | 1 | Restore the stack from redir_ckpt |
| redir_ckpt | input | CKPT_W | Stack checkpoint |
| rsv_vld | input | 1 | Resolved target for a stalled indirect |
| rsv_target | input | ADDR_W | Resolved target address |
| pred_vld | output | 1 | Prediction valid |
| pred_addr | output | ADDR_W | Next fetch address |
| pred_width | output | WID_W | Instructions to fetch |
| pred_paddr | output | PADDR_W | Physical address of the next fetch |
| pred_way | output | WAY_W | Way hint |
| pred_pa_vld | output | 1 | Physical address and way are usable |
| pred_stall | output | 1 | Fetch must wait for a resolved target |
| ras_ckpt | output | CKPT_W | Current stack state, opaque checkpoint |

## Verification
The checks assume a few things about the inputs. A stall is only resolved by a `rsv_vld` pulse or by a redirect. Updates carry widths between 1 and MAX_W. Redirects carry widths in the same range, so every valid prediction has a legal width. The stimulus trains entries only with widths from 4 to 9. It raises `rsv_vld` only while the block is stalled, holds `look_vld` low during redirect cycles, and passes back only checkpoint values it has just read from `ras_ckpt`.

// File: rtl/nfp_pkg.sv
package nfp_pkg;
   typedef enum logic [1:0] {
      BR_PLAIN = 2'd0,
      BR_CALL  = 2'd1,
      BR_RET   = 2'd2,
      BR_IND   = 2'd3
   } br_kind_e;
endpackage

// File: rtl/nfp_table.sv
module nfp_table #(
   parameter int IDX_W   = 6,
   parameter int TAG_W   = 8,
   parameter int ADDR_W  = 32,
   parameter int PADDR_W = 40,
   parameter int WAY_W   = 2,
   parameter int WID_W   = 5,
   parameter int SLOT_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   rd_idx,
   input  logic [TAG_W-1:0]   rd_tag,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [ADDR_W-1:0]  wr_target,
   input  logic [PADDR_W-1:0] wr_paddr,
   input  logic [WAY_W-1:0]   wr_way,
   input  logic [WID_W-1:0]   wr_width,
   input  logic [1:0]         wr_kind,
   input  logic [SLOT_W-1:0]  wr_slot,
   input  logic               wr_low,
   output logic               rd_hit,
   output logic [ADDR_W-1:0]  rd_target,
   output logic [PADDR_W-1:0] rd_paddr,
   output logic [WAY_W-1:0]   rd_way,
   output logic [WID_W-1:0]   rd_width,
   output logic [1:0]         rd_kind,
   output logic [SLOT_W-1:0]  rd_slot,
   output logic               rd_low
);
   localparam int ENTRIES = 1 << IDX_W;

   typedef struct packed {
      logic [TAG_W-1:0]   tag;
      logic [ADDR_W-1:0]  target;
      logic [PADDR_W-1:0] paddr;
      logic [WAY_W-1:0]   way;
      logic [WID_W-1:0]   width;
      logic [1:0]         kind;
      logic [SLOT_W-1:0]  slot;
      logic               low;
   } entry_t;

   logic [ENTRIES-1:0] vld_q;
   entry_t             mem_q [ENTRIES];
   entry_t             wdata;
   entry_t             rent;
   logic               fwd;
   logic               rvld;
   logic               tag_ok;

   assign wdata = '{tag: wr_tag, target: wr_target, paddr: wr_paddr, way: wr_way,
                    width: wr_width, kind: wr_kind, slot: wr_slot, low: wr_low};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= '0;
      else if (wr_en) vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_idx] <= wdata;
   end

   // same-index write is forwarded to the lookup
   assign fwd  = wr_en && (wr_idx == rd_idx);
   assign rent = fwd ? wdata : mem_q[rd_idx];
   assign rvld = fwd | vld_q[rd_idx];

   generate
      if (TAG_W > 1) begin : g_tag
         assign tag_ok = (rent.tag == rd_tag);
      end else begin : g_tag1
         assign tag_ok = (rent.tag[0] == rd_tag[0]);
      end
   endgenerate

   assign rd_hit    = rvld && tag_ok;
   assign rd_target = rent.target;
   assign rd_paddr  = rent.paddr;
   assign rd_way    = rent.way;
   assign rd_width  = rent.width;
   assign rd_kind   = rent.kind;
   assign rd_slot   = rent.slot;
   assign rd_low    = rent.low;
endmodule

// File: rtl/nfp_ras.sv
module nfp_ras #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int CKPT_W = PTR_W + CNT_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   input  logic              clear,
   input  logic              restore,
   input  logic [CKPT_W-1:0] restore_ckpt,
   output logic [ADDR_W-1:0] top,
   output logic              empty,
   output logic [CKPT_W-1:0] ckpt
);
   logic [ADDR_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  ck_ptr;
   logic [CNT_W-1:0]  ck_cnt;
   logic [ADDR_W-1:0] ck_top;

   assign {ck_ptr, ck_cnt, ck_top} = restore_ckpt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         ptr_q <= '0;
         cnt_q <= '0;
      end else if (restore) begin
         ptr_q <= ck_ptr;
         cnt_q <= ck_cnt;
      end else if (push) begin
         ptr_q <= ptr_q + PTR_W'(1);
         if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
      end else if (pop && cnt_q != '0) begin
         ptr_q <= ptr_q - PTR_W'(1);
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!clear && restore && ck_cnt != '0) mem_q[ck_ptr - PTR_W'(1)] <= ck_top;
      else if (!clear && !restore && push)   mem_q[ptr_q] <= push_addr;
   end

   assign top   = mem_q[ptr_q - PTR_W'(1)];
   assign empty = (cnt_q == '0);
   assign ckpt  = {ptr_q, cnt_q, top};
endmodule

// File: rtl/nfp_ctrl.sv
module nfp_ctrl
   import nfp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int PADDR_W = 40,
   parameter int WAY_W   = 2,
   parameter int WID_W   = 5,
   parameter int SLOT_W  = 4,
   parameter int MAX_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               look_vld,
   input  logic [ADDR_W-1:0]  look_addr,
   input  logic               hit,
   input  logic [ADDR_W-1:0]  e_target,
   input  logic [PADDR_W-1:0] e_paddr,
   input  logic [WAY_W-1:0]   e_way,
   input  logic [WID_W-1:0]   e_width,
   input  logic [1:0]         e_kind,
   input  logic [SLOT_W-1:0]  e_slot,
   input  logic               e_low,
   input  logic [ADDR_W-1:0]  ras_top,
   input  logic               ras_empty,
   input  logic               redir_vld,
   input  logic [ADDR_W-1:0]  redir_target,
   input  logic [PADDR_W-1:0] redir_paddr,
   input  logic [WAY_W-1:0]   redir_way,
   input  logic [WID_W-1:0]   redir_width,
   input  logic               rsv_vld,
   input  logic [ADDR_W-1:0]  rsv_target,
   output logic               o_vld,
   output logic [ADDR_W-1:0]  o_addr,
   output logic [WID_W-1:0]   o_width,
   output logic [PADDR_W-1:0] o_paddr,
   output logic [WAY_W-1:0]   o_way,
   output logic               o_pa_vld,
   output logic               o_stall,
   output logic               ras_push,
   output logic [ADDR_W-1:0]  ras_push_addr,
   output logic               ras_pop,
   output logic               stall_state
);
   localparam logic [ADDR_W-1:0] SEQ_STEP = ADDR_W'(4 * MAX_W);
   localparam logic [WID_W-1:0]  FULL_W   = WID_W'(MAX_W);

   logic stall_q;
   logic stall_d;

   assign ras_push_addr = look_addr + ADDR_W'({e_slot, 2'b00}) + ADDR_W'(4);

   always_comb begin
      o_vld    = 1'b0;
      o_addr   = look_addr + SEQ_STEP;
      o_width  = FULL_W;
      o_paddr  = '0;
      o_way    = '0;
      o_pa_vld = 1'b0;
      o_stall  = stall_q;
      ras_push = 1'b0;
      ras_pop  = 1'b0;
      stall_d  = stall_q;
      if (redir_vld) begin
         o_vld    = 1'b1;
         o_addr   = redir_target;
         o_width  = redir_width;
         o_paddr  = redir_paddr;
         o_way    = redir_way;
         o_pa_vld = 1'b1;
         o_stall  = 1'b0;
         stall_d  = 1'b0;
      end else if (stall_q) begin
         if (rsv_vld) begin
            o_vld   = 1'b1;
            o_addr  = rsv_target;
            o_stall = 1'b0;
            stall_d = 1'b0;
         end
      end else if (look_vld) begin
         if (!hit) begin
            o_vld = 1'b1;
         end else if (e_low) begin
            o_stall = 1'b1;
            stall_d = 1'b1;
         end else if (e_kind == BR_RET && !ras_empty) begin
            o_vld   = 1'b1;
            o_addr  = ras_top;
            ras_pop = 1'b1;
         end else begin
            o_vld    = 1'b1;
            o_addr   = e_target;
            o_width  = e_width;
            o_paddr  = e_paddr;
            o_way    = e_way;
            o_pa_vld = 1'b1;
            ras_push = (e_kind == BR_CALL);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stall_q <= 1'b0;
      else        stall_q <= stall_d;
   end

   assign stall_state = stall_q;
endmodule

// File: rtl/nfp_predictor.sv
module nfp_predictor #(
   parameter int ADDR_W  = 32,
   parameter int PADDR_W = 40,
   parameter int IDX_LSB = 2,
   parameter int IDX_W   = 6,
   parameter int TAG_W   = 8,
   parameter int WAYS    = 4,
   parameter int MAX_W   = 16,
   parameter int RAS_D   = 8,
   localparam int WAY_W  = $clog2(WAYS),
   localparam int WID_W  = $clog2(MAX_W + 1),
   localparam int SLOT_W = $clog2(MAX_W),
   localparam int CKPT_W = $clog2(RAS_D) + $clog2(RAS_D + 1) + ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               look_vld,
   input  logic [ADDR_W-1:0]  look_addr,
   input  logic               upd_vld,
   input  logic [ADDR_W-1:0]  upd_pc,
   input  logic [ADDR_W-1:0]  upd_target,
   input  logic [PADDR_W-1:0] upd_paddr,
   input  logic [WAY_W-1:0]   upd_way,
   input  logic [WID_W-1:0]   upd_width,
   input  logic [1:0]         upd_kind,
   input  logic [SLOT_W-1:0]  upd_slot,
   input  logic               upd_low,
   input  logic               redir_vld,
   input  logic [ADDR_W-1:0]  redir_pc,
   input  logic [ADDR_W-1:0]  redir_target,
   input  logic [PADDR_W-1:0] redir_paddr,
   input  logic [WAY_W-1:0]   redir_way,
   input  logic [WID_W-1:0]   redir_width,
   input  logic [1:0]         redir_kind,
   input  logic [SLOT_W-1:0]  redir_slot,
   input  logic               redir_ckpt_vld,
   input  logic [CKPT_W-1:0]  redir_ckpt,
   input  logic               rsv_vld,
   input  logic [ADDR_W-1:0]  rsv_target,
   output logic               pred_vld,
   output logic [ADDR_W-1:0]  pred_addr,
   output logic [WID_W-1:0]   pred_width,
   output logic [PADDR_W-1:0] pred_paddr,
   output logic [WAY_W-1:0]   pred_way,
   output logic               pred_pa_vld,
   output logic               pred_stall,
   output logic [CKPT_W-1:0]  ras_ckpt
);
   localparam int TAG_LSB = IDX_LSB + IDX_W;
   localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

   if (TAG_MSB >= ADDR_W - 1) begin : g_bad_tag
      $error("tag field must end below the top address bit");
   end
   if (RAS_D < 2 || (RAS_D & (RAS_D - 1)) != 0) begin : g_bad_ras
      $error("RAS_D must be a power of two of at least 2");
   end
   if (MAX_W < 2 || (MAX_W & (MAX_W - 1)) != 0) begin : g_bad_w
      $error("MAX_W must be a power of two of at least 2");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("WAYS must be at least 2");
   end

   // write port: a redirect retrains ahead of an ordinary update
   logic               wr_en;
   logic [ADDR_W-1:0]  wr_pc;
   logic [ADDR_W-1:0]  wr_target;
   logic [PADDR_W-1:0] wr_paddr;
   logic [WAY_W-1:0]   wr_way;
   logic [WID_W-1:0]   wr_width;
   logic [1:0]         wr_kind;
   logic [SLOT_W-1:0]  wr_slot;
   logic               wr_low;

   assign wr_en     = upd_vld | redir_vld;
   assign wr_pc     = redir_vld ? redir_pc     : upd_pc;
   assign wr_target = redir_vld ? redir_target : upd_target;
   assign wr_paddr  = redir_vld ? redir_paddr  : upd_paddr;
   assign wr_way    = redir_vld ? redir_way    : upd_way;
   assign wr_width  = redir_vld ? redir_width  : upd_width;
   assign wr_kind   = redir_vld ? redir_kind   : upd_kind;
   assign wr_slot   = redir_vld ? redir_slot   : upd_slot;
   assign wr_low    = redir_vld ? 1'b0         : upd_low;

   logic unused_pc_bits;
   assign unused_pc_bits = ^{wr_pc[IDX_LSB-1:0], wr_pc[ADDR_W-1:TAG_MSB+1]};

   logic               e_hit;
   logic [ADDR_W-1:0]  e_target;
   logic [PADDR_W-1:0] e_paddr;
   logic [WAY_W-1:0]   e_way;
   logic [WID_W-1:0]   e_width;
   logic [1:0]         e_kind;
   logic [SLOT_W-1:0]  e_slot;
   logic               e_low;

   nfp_table #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .PADDR_W(PADDR_W),
      .WAY_W(WAY_W), .WID_W(WID_W), .SLOT_W(SLOT_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(look_addr[IDX_LSB +: IDX_W]),
      .rd_tag(look_addr[TAG_LSB +: TAG_W]),
      .wr_en(wr_en),
      .wr_idx(wr_pc[IDX_LSB +: IDX_W]),
      .wr_tag(wr_pc[TAG_LSB +: TAG_W]),
      .wr_target(wr_target), .wr_paddr(wr_paddr), .wr_way(wr_way),
      .wr_width(wr_width), .wr_kind(wr_kind), .wr_slot(wr_slot), .wr_low(wr_low),
      .rd_hit(e_hit), .rd_target(e_target), .rd_paddr(e_paddr), .rd_way(e_way),
      .rd_width(e_width), .rd_kind(e_kind), .rd_slot(e_slot), .rd_low(e_low)
   );

   logic              ras_push;
   logic              ras_pop;
   logic [ADDR_W-1:0] ras_push_addr;
   logic [ADDR_W-1:0] ras_top;
   logic              ras_empty;
   logic              stall_q;

   nfp_ras #(.DEPTH(RAS_D), .ADDR_W(ADDR_W)) u_ras (
      .clk(clk), .rst_n(rst_n),
      .push(ras_push), .push_addr(ras_push_addr), .pop(ras_pop),
      .clear(redir_vld && !redir_ckpt_vld),
      .restore(redir_vld && redir_ckpt_vld),
      .restore_ckpt(redir_ckpt),
      .top(ras_top), .empty(ras_empty), .ckpt(ras_ckpt)
   );

   nfp_ctrl #(
      .ADDR_W(ADDR_W), .PADDR_W(PADDR_W), .WAY_W(WAY_W), .WID_W(WID_W),
      .SLOT_W(SLOT_W), .MAX_W(MAX_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .look_vld(look_vld), .look_addr(look_addr),
      .hit(e_hit), .e_target(e_target), .e_paddr(e_paddr), .e_way(e_way),
      .e_width(e_width), .e_kind(e_kind), .e_slot(e_slot), .e_low(e_low),
      .ras_top(ras_top), .ras_empty(ras_empty),
      .redir_vld(redir_vld), .redir_target(redir_target), .redir_paddr(redir_paddr),
      .redir_way(redir_way), .redir_width(redir_width),
      .rsv_vld(rsv_vld), .rsv_target(rsv_target),
      .o_vld(pred_vld), .o_addr(pred_addr), .o_width(pred_width),
      .o_paddr(pred_paddr), .o_way(pred_way), .o_pa_vld(pred_pa_vld),
      .o_stall(pred_stall),
      .ras_push(ras_push), .ras_push_addr(ras_push_addr), .ras_pop(ras_pop),
      .stall_state(stall_q)
   );
endmodule

// File: rtl/nfp_predictor_chk.sv
module nfp_predictor_chk #(
   parameter int WID_W = 5,
   parameter int MAX_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             redir_vld,
   input logic             rsv_vld,
   input logic             pred_vld,
   input logic             pred_stall,
   input logic             pred_pa_vld,
   input logic [WID_W-1:0] pred_width,
   input logic             stall_q
);
   // R5
   stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pred_vld && pred_stall));

   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && !rsv_vld && !redir_vld) |=> stall_q);

   // R6
   resolve_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && rsv_vld && !redir_vld) |-> (pred_vld && !pred_pa_vld && !pred_stall));

   // R6
   resolve_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && rsv_vld) |=> !stall_q);

   // R10
   redir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld |=> !stall_q);

   // R1
   width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_vld |-> (pred_width != '0 && pred_width <= WID_W'(MAX_W)));
endmodule

bind nfp_predictor nfp_predictor_chk #(.WID_W(WID_W), .MAX_W(MAX_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .redir_vld(redir_vld), .rsv_vld(rsv_vld),
   .pred_vld(pred_vld), .pred_stall(pred_stall), .pred_pa_vld(pred_pa_vld),
   .pred_width(pred_width), .stall_q(stall_q)
);

// File: tb/nfp_predictor_tb_top.sv
module nfp_predictor_tb_top;
   localparam int CKW = 3 + 4 + 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        look_vld;
   logic [31:0] look_addr;
   logic        upd_vld;
   logic [31:0] upd_pc, upd_target;
   logic [39:0] upd_paddr;
   logic [1:0]  upd_way;
   logic [4:0]  upd_width;
   logic [1:0]  upd_kind;
   logic [3:0]  upd_slot;
   logic        upd_low;
   logic        redir_vld;
   logic [31:0] redir_pc, redir_target;
   logic [39:0] redir_paddr;
   logic [1:0]  redir_way;
   logic [4:0]  redir_width;
   logic [1:0]  redir_kind;
   logic [3:0]  redir_slot;
   logic        redir_ckpt_vld;
   logic [CKW-1:0] redir_ckpt;
   logic        rsv_vld;
   logic [31:0] rsv_target;
   logic        pred_vld;
   logic [31:0] pred_addr;
   logic [4:0]  pred_width;
   logic [39:0] pred_paddr;
   logic [1:0]  pred_way;
   logic        pred_pa_vld;
   logic        pred_stall;
   logic [CKW-1:0] ras_ckpt;

   nfp_predictor dut_i (.*);

   typedef struct {
      string       req;
      logic        vld;
      logic        stall;
      logic [31:0] addr;
      logic [4:0]  width;
      logic        pav;
      logic [39:0] paddr;
      logic [1:0]  way;
   } exp_t;

   exp_t sb[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic idle();
      look_vld = 0; look_addr = '0;
      upd_vld = 0; upd_pc = '0; upd_target = '0; upd_paddr = '0; upd_way = '0;
      upd_width = '0; upd_kind = '0; upd_slot = '0; upd_low = 0;
      redir_vld = 0; redir_pc = '0; redir_target = '0; redir_paddr = '0; redir_way = '0;
      redir_width = '0; redir_kind = '0; redir_slot = '0; redir_ckpt_vld = 0; redir_ckpt = '0;
      rsv_vld = 0; rsv_target = '0;
   endtask

   task automatic tick();
      @(negedge clk);
      idle();
   endtask

   task automatic expect_out(string req, logic v, logic st, logic [31:0] a, logic [4:0] w,
                             logic pav, logic [39:0] pa, logic [1:0] way);
      exp_t e;
      e.req = req; e.vld = v; e.stall = st; e.addr = a; e.width = w;
      e.pav = pav; e.paddr = pa; e.way = way;
      sb.push_back(e);
   endtask

   task automatic set_upd(logic [31:0] pc, logic [31:0] tgt, logic [39:0] pa, logic [1:0] way,
                          logic [4:0] w, logic [1:0] kind, logic [3:0] slot, logic low);
      upd_vld = 1; upd_pc = pc; upd_target = tgt; upd_paddr = pa; upd_way = way;
      upd_width = w; upd_kind = kind; upd_slot = slot; upd_low = low;
   endtask

   task automatic train(logic [31:0] pc, logic [31:0] tgt, logic [39:0] pa, logic [1:0] way,
                        logic [4:0] w, logic [1:0] kind, logic [3:0] slot, logic low);
      tick();
      set_upd(pc, tgt, pa, way, w, kind, slot, low);
   endtask

   task automatic look(logic [31:0] a);
      tick();
      look_vld = 1; look_addr = a;
   endtask

   task automatic miss(string req, logic [31:0] a);
      expect_out(req, 1, 0, a + 32'd64, 5'd16, 0, '0, '0);
   endtask

   // monitor: compares a quarter period after inputs settle
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            checks++;
            bad = (pred_vld !== e.vld) || (pred_stall !== e.stall);
            if (e.vld) begin
               bad = bad || (pred_addr !== e.addr) || (pred_width !== e.width) ||
                     (pred_pa_vld !== e.pav);
               if (e.pav) bad = bad || (pred_paddr !== e.paddr) || (pred_way !== e.way);
            end
            if (bad) begin
               errors++;
               $display("FAIL %s: got vld=%0b stall=%0b addr=%h w=%0d pav=%0b pa=%h way=%0d exp vld=%0b stall=%0b addr=%h w=%0d pav=%0b pa=%h way=%0d",
                        e.req, pred_vld, pred_stall, pred_addr, pred_width, pred_pa_vld,
                        pred_paddr, pred_way, e.vld, e.stall, e.addr, e.width, e.pav,
                        e.paddr, e.way);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CKW-1:0] saved;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R13 reset state and empty table
      tick();
      expect_out("R13", 0, 0, '0, '0, 0, '0, '0);
      look(32'h1000); miss("R13", 32'h1000);

      // R1 miss on another index
      look(32'h2344); miss("R1", 32'h2344);

      // R2 plain hit
      train(32'h1000, 32'h2000, 40'hA_0000_2000, 2'd2, 5'd5, 2'd0, 4'd0, 0);
      look(32'h1000); expect_out("R2", 1, 0, 32'h2000, 5'd5, 1, 40'hA_0000_2000, 2'd2);

      // R3 same index, different tag
      look(32'h1100); miss("R3", 32'h1100);

      // R4 update and lookup to the same index in one cycle
      tick();
      set_upd(32'h1004, 32'h3000, 40'hB_0000_3000, 2'd1, 5'd7, 2'd0, 4'd0, 0);
      look_vld = 1; look_addr = 32'h1004;
      expect_out("R4", 1, 0, 32'h3000, 5'd7, 1, 40'hB_0000_3000, 2'd1);

      // R7 call pushes, return pops
      train(32'h4000, 32'h5000, 40'hC_0000_5000, 2'd3, 5'd4, 2'd1, 4'd3, 0);
      train(32'h5050, 32'h9999_0000, 40'hD_9999_0000, 2'd1, 5'd6, 2'd2, 4'd0, 0);
      look(32'h4000); expect_out("R7", 1, 0, 32'h5000, 5'd4, 1, 40'hC_0000_5000, 2'd3);
      look(32'h5050); expect_out("R7", 1, 0, 32'h4010, 5'd16, 0, '0, '0);
      // R8 return on empty stack
      look(32'h5050); expect_out("R8", 1, 0, 32'h9999_0000, 5'd6, 1, 40'hD_9999_0000, 2'd1);

      // R5 low-confidence indirect stalls
      train(32'h6000, 32'h6600, 40'hE_0000_6600, 2'd0, 5'd8, 2'd3, 4'd0, 1);
      look(32'h6000); expect_out("R5", 0, 1, '0, '0, 0, '0, '0);
      look(32'h1004); expect_out("R5", 0, 1, '0, '0, 0, '0, '0);
      look(32'h2344); expect_out("R5", 0, 1, '0, '0, 0, '0, '0);
      // R6 resolved target ends the stall
      tick(); rsv_vld = 1; rsv_target = 32'h7000;
      expect_out("R6", 1, 0, 32'h7000, 5'd16, 0, '0, '0);
      look(32'h1004); expect_out("R6", 1, 0, 32'h3000, 5'd7, 1, 40'hB_0000_3000, 2'd1);

      // R9 stack overflow: nine calls, eight pops, then empty
      for (int i = 0; i < 9; i++)
         train(32'h8000 + 32'(4 * i), 32'hA000 + 32'(256 * i), 40'hF_0000_0000 + 40'(256 * i),
               2'(i), 5'd8, 2'd1, 4'd0, 0);
      for (int i = 0; i < 9; i++) begin
         look(32'h8000 + 32'(4 * i));
         expect_out("R9", 1, 0, 32'hA000 + 32'(256 * i), 5'd8, 1,
                    40'hF_0000_0000 + 40'(256 * i), 2'(i));
      end
      for (int i = 8; i >= 1; i--) begin
         look(32'h5050);
         expect_out("R9", 1, 0, 32'h8004 + 32'(4 * i), 5'd16, 0, '0, '0);
      end
      look(32'h5050); expect_out("R9", 1, 0, 32'h9999_0000, 5'd6, 1, 40'hD_9999_0000, 2'd1);

      // R10 redirect output; R11 clear without checkpoint
      look(32'h8000); expect_out("R11", 1, 0, 32'hA000, 5'd8, 1, 40'hF_0000_0000, 2'd0);
      tick();
      redir_vld = 1; redir_pc = 32'hB010; redir_target = 32'hD000; redir_paddr = 40'h1_0000_D000;
      redir_way = 2'd3; redir_width = 5'd9; redir_kind = 2'd0;
      expect_out("R10", 1, 0, 32'hD000, 5'd9, 1, 40'h1_0000_D000, 2'd3);
      look(32'h5050); expect_out("R11", 1, 0, 32'h9999_0000, 5'd6, 1, 40'hD_9999_0000, 2'd1);
      look(32'hB010); expect_out("R10", 1, 0, 32'hD000, 5'd9, 1, 40'h1_0000_D000, 2'd3);

      // R11 restore from checkpoint
      look(32'h8000); expect_out("R11", 1, 0, 32'hA000, 5'd8, 1, 40'hF_0000_0000, 2'd0);
      tick(); saved = ras_ckpt;
      look_vld = 1; look_addr = 32'h8004;
      expect_out("R11", 1, 0, 32'hA100, 5'd8, 1, 40'hF_0000_0100, 2'd1);
      tick();
      redir_vld = 1; redir_pc = 32'hB010; redir_target = 32'hD000; redir_paddr = 40'h1_0000_D000;
      redir_way = 2'd3; redir_width = 5'd9; redir_ckpt_vld = 1; redir_ckpt = saved;
      expect_out("R10", 1, 0, 32'hD000, 5'd9, 1, 40'h1_0000_D000, 2'd3);
      look(32'h5050); expect_out("R11", 1, 0, 32'h8004, 5'd16, 0, '0, '0);

      // R12 redirect wins over a same-cycle update
      tick();
      set_upd(32'hC000, 32'hE000, 40'h2_0000_E000, 2'd0, 5'd4, 2'd0, 4'd0, 0);
      redir_vld = 1; redir_pc = 32'hC000; redir_target = 32'hF000; redir_paddr = 40'h3_0000_F000;
      redir_way = 2'd2; redir_width = 5'd5;
      expect_out("R12", 1, 0, 32'hF000, 5'd5, 1, 40'h3_0000_F000, 2'd2);
      look(32'hC000); expect_out("R12", 1, 0, 32'hF000, 5'd5, 1, 40'h3_0000_F000, 2'd2);

      tick();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule